// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block is the narrow window through which a host moves data in and out of the packet buffer memory of a network controller. The host first loads a transfer pointer and a byte count. It then issues a series of reads or writes on a single data port. Each strobe touches packet memory at the current pointer. After the access the pointer moves forward and the count moves down. When the pointer reaches the end of the receive ring it folds back to the first ring page, so a packet that crosses the end of the ring can be read out as one continuous run.

A run-time configuration bit picks the transfer width. In byte mode each strobe carries one byte. In word mode each strobe carries two bytes, packed little-endian: the byte at the pointer sits in the low half. When an access drives the count down to zero, the block raises a one-cycle completion pulse for the interrupt logic. The packet memory sits outside the block and is reached through a two-lane port with one cycle of read latency. The default memory size is 32768 bytes.

Top module: `rdma_port`

## Requirements
- R1: After reset the pointer and the count are 0, and `dma_done_o` and `host_rvalid_o` are low.
- R2: A pulse on `addr_ld_i` or `cnt_ld_i` loads `addr_val_i` into the pointer or `cnt_val_i` into the count at the next clock edge. A load takes priority over any pointer or count update from an access in the same cycle. The memory access itself still uses the old pointer.
- R3: In byte mode (`word_mode_i`=0), `host_rd_i` reads the byte at the pointer. One cycle later `host_rvalid_o` is high and `host_rdata_o` is {8'h00, byte}.
- R4: In word mode (`word_mode_i`=1), a read returns the byte at pointer+1 in bits 15:8 and the byte at the pointer in bits 7:0.
- R5: In byte mode a write stores `host_wdata_i[7:0]` at the pointer only, with lane enable `mem_be_o`=2'b01. In word mode a write stores bits 7:0 at the pointer and bits 15:8 at pointer+1, with `mem_be_o`=2'b11.
- R6: An access with a nonzero count advances the pointer by 1 in byte mode or by 2 in word mode. It lowers the count by the same amount, and the count saturates at 0.
- R7: If the advanced pointer equals `ring_stop_pg_i`*256, the pointer becomes `ring_start_pg_i`*256 instead.
- R8: `dma_done_o` is high for exactly one cycle, in the cycle after an access that takes the count from nonzero to 0. A load never raises it.
- R9: An access made while the count is 0 still reaches memory, but it leaves the pointer and count unchanged and raises no completion pulse.
- R10: If `host_rd_i` and `host_wr_i` are both high, the read is performed. The write is dropped: memory is not written, and the pointer advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 = 16-bit transfers, 0 = 8-bit transfers |
| ring_start_pg_i | input | 8 | First page of the receive ring |
| ring_stop_pg_i | input | 8 | Page one past the end of the receive ring |
| addr_ld_i | input | 1 | Load the transfer pointer |
| addr_val_i | input | 16 | Pointer load value |
| cnt_ld_i | input | 1 | Load the byte count |
| cnt_val_i | input | 16 | Count load value |
| host_rd_i | input | 1 | Host read strobe on the data port |
| host_wr_i | input | 1 | Host write strobe on the data port |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, valid with host_rvalid_o |
| host_rvalid_o | output | 1 | Read data valid, one cycle after host_rd_i |
| cur_addr_o | output | 16 | Current transfer pointer |
| cur_cnt_o | output | 16 | Remaining byte count |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 2 | Lane enables, lane 0 = pointer, lane 1 = pointer+1 |
| mem_addr_lo_o | output | 15 | Lane 0 byte address |
| mem_addr_hi_o | output | 15 | Lane 1 byte address |
| mem_wdata_o | output | 16 | Lane write data, lane 1 in bits 15:8 |
| mem_rdata_i | input | 16 | Lane read data, one cycle after the request |
| dma_done_o | output | 1 | Transfer complete pulse |

## Verification
One access can land on the ring end and finish the transfer at the same time. The pointer then has to fold back, and the count has to reach zero with a pulse, all in a single edge. The bench provokes this by placing the pointer one byte below the stop page with a count of one, then issuing a byte read. The sampled cycle must show the start-page address, a zero count and the completion pulse together. A second collision is a pointer or count load arriving in the same cycle as a data strobe. Here the bench checks that the read data still comes from the old pointer, while the registers take the loaded values.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int unsigned PTR_W  = 16;
  localparam int unsigned PG_W   = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BYTE_W = 8;

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [PG_W-1:0]  pg_t;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  function automatic ptr_t pg_to_ptr(pg_t pg);
    return {pg, {(PTR_W-PG_W){1'b0}}};
  endfunction
endpackage

// File: rtl/rdma_arb.sv
module rdma_arb
  import rdma_pkg::*;
(
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       word_i,
  output acc_e       acc_o,
  output logic [1:0] step_o
);
  // read wins over a same-cycle write
  always_comb begin
    if (rd_i)      acc_o = ACC_RD;
    else if (wr_i) acc_o = ACC_WR;
    else           acc_o = ACC_NONE;
  end

  assign step_o = word_i ? 2'd2 : 2'd1;
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr
  import rdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  ptr_t       ld_val_i,
  input  logic       adv_i,
  input  logic [1:0] step_i,
  input  pg_t        start_pg_i,
  input  pg_t        stop_pg_i,
  output ptr_t       addr_o
);
  ptr_t addr_q, addr_sum, addr_nxt;

  always_comb begin
    addr_sum = addr_q + ptr_t'(step_i);
    addr_nxt = (addr_sum == pg_to_ptr(stop_pg_i)) ? pg_to_ptr(start_pg_i) : addr_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (ld_i)  addr_q <= ld_val_i;
    else if (adv_i) addr_q <= addr_nxt;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/rdma_cnt.sv
module rdma_cnt
  import rdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  ptr_t       ld_val_i,
  input  logic       acc_i,
  input  logic [1:0] step_i,
  output ptr_t       cnt_o,
  output logic       live_o,
  output logic       done_o
);
  ptr_t cnt_q;
  logic done_q, last;

  assign live_o = (cnt_q != '0);
  assign last   = (cnt_q <= ptr_t'(step_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (ld_i) begin
      cnt_q  <= ld_val_i;
      done_q <= 1'b0;
    end else if (acc_i && live_o) begin
      cnt_q  <= last ? '0 : cnt_q - ptr_t'(step_i);
      done_q <= last;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/rdma_lane.sv
module rdma_lane
  import rdma_pkg::*;
#(
  parameter int unsigned MEM_AW = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  acc_e                    acc_i,
  input  logic                    word_i,
  input  ptr_t                    addr_i,
  input  logic [LANES*BYTE_W-1:0] wdata_i,
  output logic                    req_o,
  output logic                    we_o,
  output logic [LANES-1:0]        be_o,
  output logic [MEM_AW-1:0]       lane_addr_o [LANES],
  output logic [LANES*BYTE_W-1:0] mem_wdata_o,
  input  logic [LANES*BYTE_W-1:0] mem_rdata_i,
  output logic [LANES*BYTE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  logic rvalid_q, word_q;

  assign req_o       = (acc_i != ACC_NONE);
  assign we_o        = (acc_i == ACC_WR);
  assign mem_wdata_o = wdata_i;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic en;
    ptr_t la;
    assign en             = (i == 0) || word_i;
    assign la             = addr_i + ptr_t'(i);
    assign lane_addr_o[i] = la[MEM_AW-1:0];
    assign be_o[i]        = we_o && en;
    assign rdata_o[i*BYTE_W +: BYTE_W] =
      (rvalid_q && ((i == 0) || word_q)) ? mem_rdata_i[i*BYTE_W +: BYTE_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      word_q   <= 1'b0;
    end else begin
      rvalid_q <= (acc_i == ACC_RD);
      word_q   <= word_i;
    end
  end

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 32768,
  localparam int unsigned MEM_AW   = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic [7:0]        ring_start_pg_i,
  input  logic [7:0]        ring_stop_pg_i,
  input  logic              addr_ld_i,
  input  logic [15:0]       addr_val_i,
  input  logic              cnt_ld_i,
  input  logic [15:0]       cnt_val_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [15:0]       host_wdata_i,
  output logic [15:0]       host_rdata_o,
  output logic              host_rvalid_o,
  output logic [15:0]       cur_addr_o,
  output logic [15:0]       cur_cnt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_be_o,
  output logic [MEM_AW-1:0] mem_addr_lo_o,
  output logic [MEM_AW-1:0] mem_addr_hi_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              dma_done_o
);
  acc_e        acc;
  logic [1:0]  step;
  logic        live;
  ptr_t        addr;
  logic [MEM_AW-1:0] lane_addr [LANES];

  rdma_arb i_arb (
    .rd_i   (host_rd_i),
    .wr_i   (host_wr_i),
    .word_i (word_mode_i),
    .acc_o  (acc),
    .step_o (step)
  );

  rdma_cnt i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_ld_i),
    .ld_val_i (cnt_val_i),
    .acc_i    (acc != ACC_NONE),
    .step_i   (step),
    .cnt_o    (cur_cnt_o),
    .live_o   (live),
    .done_o   (dma_done_o)
  );

  rdma_ptr i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (addr_ld_i),
    .ld_val_i   (addr_val_i),
    .adv_i      ((acc != ACC_NONE) && live),
    .step_i     (step),
    .start_pg_i (ring_start_pg_i),
    .stop_pg_i  (ring_stop_pg_i),
    .addr_o     (addr)
  );

  rdma_lane #(.MEM_AW(MEM_AW)) i_lane (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .word_i      (word_mode_i),
    .addr_i      (addr),
    .wdata_i     (host_wdata_i),
    .req_o       (mem_req_o),
    .we_o        (mem_we_o),
    .be_o        (mem_be_o),
    .lane_addr_o (lane_addr),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (host_rdata_o),
    .rvalid_o    (host_rvalid_o)
  );

  assign cur_addr_o    = addr;
  assign mem_addr_lo_o = lane_addr[0];
  assign mem_addr_hi_o = lane_addr[1];
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_mode_i,
  input logic        addr_ld_i,
  input logic        cnt_ld_i,
  input logic [15:0] cnt_val_i,
  input logic        host_rd_i,
  input logic        host_wr_i,
  input logic        host_rvalid_o,
  input logic [15:0] cur_addr_o,
  input logic [15:0] cur_cnt_o,
  input logic        mem_we_o,
  input logic [1:0]  mem_be_o,
  input logic        dma_done_o
);
  assert_done_at_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_o |-> (cur_cnt_o == 16'd0));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_o |=> !dma_done_o);

  assert_idle_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_cnt_o == 16'd0) && (host_rd_i || host_wr_i) && !addr_ld_i && !cnt_ld_i)
    |=> ($stable(cur_addr_o) && $stable(cur_cnt_o) && !dma_done_o));

  assert_rd_beats_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_wr_i) |-> !mem_we_o);

  assert_rvalid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i |=> host_rvalid_o);

  assert_cnt_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ld_i |=> (cur_cnt_o == $past(cnt_val_i)));

  assert_byte_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_mode_i && (host_rd_i || host_wr_i) && (cur_cnt_o > 16'd1) && !cnt_ld_i)
    |=> (cur_cnt_o == $past(cur_cnt_o) - 16'd1));

  assert_byte_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !host_rd_i && !word_mode_i) |-> (mem_be_o == 2'b01));
endmodule

bind rdma_port rdma_port_chk i_chk (.*);

// File: tb/test_rdma_port.sv
module test_rdma_port;
  localparam int unsigned MAW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        word_mode, addr_ld, cnt_ld, host_rd, host_wr;
  logic [7:0]  start_pg, stop_pg;
  logic [15:0] addr_val, cnt_val, host_wdata, host_rdata, cur_addr, cur_cnt;
  logic [15:0] mem_wdata, mem_rdata;
  logic        host_rvalid, mem_req, mem_we, dma_done;
  logic [1:0]  mem_be;
  logic [MAW-1:0] mem_addr_lo, mem_addr_hi;

  rdma_port i_rdma_port (
    .clk_i(clk), .rst_ni(rst_n), .word_mode_i(word_mode),
    .ring_start_pg_i(start_pg), .ring_stop_pg_i(stop_pg),
    .addr_ld_i(addr_ld), .addr_val_i(addr_val), .cnt_ld_i(cnt_ld), .cnt_val_i(cnt_val),
    .host_rd_i(host_rd), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .host_rvalid_o(host_rvalid),
    .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_be_o(mem_be),
    .mem_addr_lo_o(mem_addr_lo), .mem_addr_hi_o(mem_addr_hi),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .dma_done_o(dma_done)
  );

  // packet memory model, 1 KiB window, one cycle read latency
  logic [7:0] mem [1024];
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      if (mem_be[0]) mem[mem_addr_lo[9:0]] <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr_hi[9:0]] <= mem_wdata[15:8];
    end
    if (mem_req && !mem_we) mem_rdata <= {mem[mem_addr_hi[9:0]], mem[mem_addr_lo[9:0]]};
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // op: 0 write, 1 read, 2 load pointer (wdata) and count (aux)
  typedef struct packed {
    logic [1:0]  op;
    logic        word;
    logic [15:0] wdata;
    logic [15:0] aux;
    logic [15:0] exp_addr;
    logic [15:0] exp_cnt;
    logic        exp_done;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 16'h00A1, 16'h0000, 16'h01FD, 16'd7, 1'b0},
    '{2'd0, 1'b1, 16'hB3B2, 16'h0000, 16'h01FF, 16'd5, 1'b0},
    '{2'd0, 1'b0, 16'hFFC4, 16'h0000, 16'h0000, 16'd4, 1'b0},
    '{2'd0, 1'b1, 16'hD6D5, 16'h0000, 16'h0002, 16'd2, 1'b0},
    '{2'd0, 1'b1, 16'hE8E7, 16'h0000, 16'h0004, 16'd0, 1'b1},
    '{2'd2, 1'b0, 16'h01FC, 16'd9,    16'h01FC, 16'd9, 1'b0},
    '{2'd1, 1'b0, 16'h0000, 16'h00A1, 16'h01FD, 16'd8, 1'b0},
    '{2'd1, 1'b1, 16'h0000, 16'hB3B2, 16'h01FF, 16'd6, 1'b0},
    '{2'd1, 1'b0, 16'h0000, 16'h00C4, 16'h0000, 16'd5, 1'b0},
    '{2'd1, 1'b1, 16'h0000, 16'hD6D5, 16'h0002, 16'd3, 1'b0},
    '{2'd1, 1'b1, 16'h0000, 16'hE8E7, 16'h0004, 16'd1, 1'b0},
    '{2'd1, 1'b0, 16'h0000, 16'h005E, 16'h0005, 16'd0, 1'b1}
  };

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    addr_ld = 1'b1; addr_val = a; cnt_ld = 1'b1; cnt_val = c;
    @(negedge clk);
    addr_ld = 1'b0; cnt_ld = 1'b0;
  endtask

  // one strobe; returns after the edge, sampled at the negedge
  task automatic access(input logic rd, input logic wr, input logic wd, input logic [15:0] d);
    @(negedge clk);
    host_rd = rd; host_wr = wr; word_mode = wd; host_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    host_rd = 1'b0; host_wr = 1'b0; addr_ld = 1'b0; cnt_ld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    word_mode = 1'b0; start_pg = 8'h00; stop_pg = 8'h02;
    addr_ld = 1'b0; addr_val = '0; cnt_ld = 1'b0; cnt_val = '0;
    host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 addr", 32'(cur_addr), 32'h0);
    chk("R1 cnt", 32'(cur_cnt), 32'h0);
    chk("R1 done", 32'(dma_done), 32'h0);
    chk("R1 rvalid", 32'(host_rvalid), 32'h0);
    rst_n = 1'b1;

    load(16'h01FC, 16'd8);
    chk("R2 load addr", 32'(cur_addr), 32'h01FC);
    chk("R2 load cnt", 32'(cur_cnt), 32'd8);
    chk("R8 no pulse on load", 32'(dma_done), 32'h0);

    // R3 R4 R5 R6 R7 R8 table walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].op == 2'd2) begin
        load(VEC[v].wdata, VEC[v].aux);
      end else begin
        access(VEC[v].op == 2'd1, VEC[v].op == 2'd0, VEC[v].word, VEC[v].wdata);
        if (VEC[v].op == 2'd1) begin
          chk(VEC[v].word ? "R4 word read" : "R3 byte read", 32'(host_rdata), 32'(VEC[v].aux));
          chk("R3 rvalid", 32'(host_rvalid), 32'h1);
        end
        idle();
      end
      chk("R6 R7 addr", 32'(cur_addr), 32'(VEC[v].exp_addr));
      chk("R6 cnt", 32'(cur_cnt), 32'(VEC[v].exp_cnt));
      chk("R8 done", 32'(dma_done), 32'(VEC[v].exp_done));
    end
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(dma_done), 32'h0);

    // R9 access at zero count
    access(1'b1, 1'b0, 1'b0, 16'h0);
    idle();
    chk("R9 data", 32'(host_rdata), 32'h005F);
    chk("R9 addr", 32'(cur_addr), 32'h0005);
    chk("R9 cnt", 32'(cur_cnt), 32'h0);
    chk("R9 no pulse", 32'(dma_done), 32'h0);

    // R10 read and write together
    load(16'h0010, 16'd4);
    access(1'b1, 1'b1, 1'b0, 16'h0099);
    idle();
    chk("R10 read data", 32'(host_rdata), 32'h004A);
    chk("R10 single advance", 32'(cur_addr), 32'h0011);
    chk("R10 cnt", 32'(cur_cnt), 32'd3);
    load(16'h0010, 16'd4);
    access(1'b1, 1'b0, 1'b0, 16'h0);
    idle();
    chk("R10 write dropped", 32'(host_rdata), 32'h004A);

    // R2 load in the same cycle as an access
    @(negedge clk);
    host_rd = 1'b1; word_mode = 1'b0; addr_ld = 1'b1; addr_val = 16'h0040;
    @(negedge clk);
    idle();
    chk("R2 old pointer read", 32'(host_rdata), 32'h004B);
    chk("R2 addr load wins", 32'(cur_addr), 32'h0040);
    chk("R2 cnt still steps", 32'(cur_cnt), 32'd2);
    @(negedge clk);
    host_rd = 1'b1; cnt_ld = 1'b1; cnt_val = 16'd7;
    @(negedge clk);
    idle();
    chk("R2 cnt load wins", 32'(cur_cnt), 32'd7);
    chk("R2 addr still steps", 32'(cur_addr), 32'h0041);

    // R7 word wrap with a nonzero ring start
    start_pg = 8'h01; stop_pg = 8'h02;
    load(16'h01FE, 16'd4);
    access(1'b1, 1'b0, 1'b1, 16'h0);
    idle();
    chk("R7 R4 word at ring end", 32'(host_rdata), 32'hC4B3);
    chk("R7 word wrap", 32'(cur_addr), 32'h0100);
    chk("R7 cnt", 32'(cur_cnt), 32'd2);

    // R7 R8 wrap and completion on the same access
    load(16'h01FF, 16'd1);
    access(1'b1, 1'b0, 1'b0, 16'h0);
    idle();
    chk("R7 wrap with done", 32'(cur_addr), 32'h0100);
    chk("R8 cnt zero", 32'(cur_cnt), 32'h0);
    chk("R8 done with wrap", 32'(dma_done), 32'h1);

    // R6 word access with one byte left saturates
    load(16'h0030, 16'd1);
    access(1'b1, 1'b0, 1'b1, 16'h0);
    idle();
    chk("R4 word data", 32'(host_rdata), 32'h6B6A);
    chk("R6 saturate cnt", 32'(cur_cnt), 32'h0);
    chk("R6 word addr", 32'(cur_addr), 32'h0032);
    chk("R8 done sat", 32'(dma_done), 32'h1);

    // R5 lane enables for a word write
    load(16'h0050, 16'd2);
    @(negedge clk);
    host_wr = 1'b1; word_mode = 1'b1; host_wdata = 16'h1234;
    #1 chk("R5 word lanes", 32'(mem_be), 32'h3);
    @(negedge clk);
    idle();
    chk("R5 low byte", 32'(mem[16'h0050]), 32'h34);
    chk("R5 high byte", 32'(mem[16'h0051]), 32'h12);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule